// File: doc/BRIEF.md
# Multiply Special-Operand Resolver

This block sits in front of a floating-point mantissa multiplier. It receives two operands that are already unpacked into a class code, a sign, an exponent and a mantissa. It then decides whether the product can be settled without arithmetic. Zeros, infinities and NaNs all give results that are fixed by their classes and signs. Only a pair of ordinary numbers needs the multiplier.

First, the two operands are ordered so that the operand whose class weighs more becomes the second operand. After that, a fixed priority chain picks the outcome. If the outcome is special, the block presents the resulting operand and raises the matching invalid-operation flag. If both operands are numbers, it raises `compute` instead, which starts the multiplier.

A parameter selects between a purely combinational stage and a single registered stage. Class detection from packed encodings and rounding are handled elsewhere.

Top module: `mul_special_resolve`

## Requirements
- R1: Class codes are zero=0, number=1, infinity=2, quiet NaN=3, signalling NaN=4, and class weight rises with the code. The operand with the larger weight becomes the second operand. On equal weight, input A stays first and input B stays second.
- R2: When the second operand is a quiet or signalling NaN, the result is that operand's class, exponent and mantissa. Its sign is the XOR of both input signs. `flag_snan`=1 and `flag_imz`=0.
- R3: When the second operand is infinity and the first is zero, the result is the default NaN. The default NaN has class 3, sign 0, an all-ones exponent and a mantissa with only its top bit set. `flag_imz`=1 and `flag_snan`=0.
- R4: When the second operand is infinity and the first is a number or infinity, the result is infinity. It takes the second operand's exponent and mantissa, and its sign is the XOR of both signs. No flag is raised.
- R5: When the first operand (after ordering) is zero and the second is zero or a number, the result is zero. It takes the first operand's exponent and mantissa, and its sign is the XOR of both signs. No flag is raised.
- R6: When both operands are numbers, `compute`=1 and both flags are 0. The result is class 1 with the XOR sign and a zero exponent and mantissa.
- R7: `compute` is 0 whenever either operand is not a number.
- R8: With REGISTERED=1, every output reflects the inputs one clock earlier. While `rst_n` is low, the outputs are class 0, sign 0, exponent 0, mantissa 0, with both flags and `compute` at 0.
- R9: The unused class codes 5, 6 and 7 are treated exactly as a signalling NaN (code 4), in weight and in result. The class code reported for them is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used when REGISTERED=1 |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| a_cls | input | 3 | Class code of input A |
| a_sgn | input | 1 | Sign of input A |
| a_exp | input | EXP_W | Exponent of input A |
| a_man | input | MANT_W | Mantissa of input A |
| b_cls | input | 3 | Class code of input B |
| b_sgn | input | 1 | Sign of input B |
| b_exp | input | EXP_W | Exponent of input B |
| b_man | input | MANT_W | Mantissa of input B |
| res_cls | output | 3 | Class code of the resolved result |
| res_sgn | output | 1 | Sign of the result |
| res_exp | output | EXP_W | Exponent of the result |
| res_man | output | MANT_W | Mantissa of the result |
| flag_snan | output | 1 | Invalid operation: NaN operand |
| flag_imz | output | 1 | Invalid operation: infinity times zero |
| compute | output | 1 | Both operands are numbers; start the multiplier |

## Verification
The hardest situations to reach from the ports are the ordering corners. These include two operands of equal class, a signalling NaN on input A against a quiet NaN on input B, and the unused class codes competing with a real signalling NaN. Each of these shows up only in which operand's payload and class appear at the output. The bench therefore sweeps every pair of the eight class codes against every sign combination. It gives the two inputs distinct exponents and mantissas, so that the payload on the output tells which operand was chosen. Latency and reset values are checked separately around the registered stage.

// File: rtl/msr_pkg.sv
package msr_pkg;
   localparam int CLS_W = 3;
   localparam logic [CLS_W-1:0] CLS_ZERO = 3'd0;
   localparam logic [CLS_W-1:0] CLS_NUM  = 3'd1;
   localparam logic [CLS_W-1:0] CLS_INF  = 3'd2;
   localparam logic [CLS_W-1:0] CLS_QNAN = 3'd3;
   localparam logic [CLS_W-1:0] CLS_SNAN = 3'd4;

   // Fold the unused codes onto the heaviest legal class.
   function automatic logic [CLS_W-1:0] cls_fold(input logic [CLS_W-1:0] c);
      return (c > CLS_SNAN) ? CLS_SNAN : c;
   endfunction

   function automatic logic cls_is_nan(input logic [CLS_W-1:0] c);
      return (c == CLS_QNAN) || (c == CLS_SNAN);
   endfunction
endpackage

// File: rtl/msr_order.sv
module msr_order
   import msr_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int MANT_W = 53
) (
   input  logic [CLS_W-1:0]  a_cls,
   input  logic              a_sgn,
   input  logic [EXP_W-1:0]  a_exp,
   input  logic [MANT_W-1:0] a_man,
   input  logic [CLS_W-1:0]  b_cls,
   input  logic              b_sgn,
   input  logic [EXP_W-1:0]  b_exp,
   input  logic [MANT_W-1:0] b_man,
   output logic [CLS_W-1:0]  lt_cls,
   output logic              lt_sgn,
   output logic [EXP_W-1:0]  lt_exp,
   output logic [MANT_W-1:0] lt_man,
   output logic [CLS_W-1:0]  hv_cls,
   output logic              hv_sgn,
   output logic [EXP_W-1:0]  hv_exp,
   output logic [MANT_W-1:0] hv_man
);
   logic [CLS_W-1:0] a_w, b_w;
   logic             swap;

   assign a_w  = cls_fold(a_cls);
   assign b_w  = cls_fold(b_cls);
   // Strict compare: a tie leaves the input order untouched.
   assign swap = (a_w > b_w);

   always_comb begin
      if (swap) begin
         lt_cls = b_w;  lt_sgn = b_sgn; lt_exp = b_exp; lt_man = b_man;
         hv_cls = a_w;  hv_sgn = a_sgn; hv_exp = a_exp; hv_man = a_man;
      end else begin
         lt_cls = a_w;  lt_sgn = a_sgn; lt_exp = a_exp; lt_man = a_man;
         hv_cls = b_w;  hv_sgn = b_sgn; hv_exp = b_exp; hv_man = b_man;
      end
   end
endmodule

// File: rtl/msr_decide.sv
module msr_decide
   import msr_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int MANT_W = 53
) (
   input  logic [CLS_W-1:0]  lt_cls,
   input  logic              lt_sgn,
   input  logic [EXP_W-1:0]  lt_exp,
   input  logic [MANT_W-1:0] lt_man,
   input  logic [CLS_W-1:0]  hv_cls,
   input  logic              hv_sgn,
   input  logic [EXP_W-1:0]  hv_exp,
   input  logic [MANT_W-1:0] hv_man,
   output logic [CLS_W-1:0]  d_cls,
   output logic              d_sgn,
   output logic [EXP_W-1:0]  d_exp,
   output logic [MANT_W-1:0] d_man,
   output logic              d_snan,
   output logic              d_imz,
   output logic              d_go
);
   localparam logic [EXP_W-1:0]  DNAN_EXP = '1;
   localparam logic [MANT_W-1:0] DNAN_MAN = {1'b1, {(MANT_W-1){1'b0}}};

   logic sx;
   assign sx = lt_sgn ^ hv_sgn;

   always_comb begin
      d_cls  = CLS_NUM;
      d_sgn  = sx;
      d_exp  = '0;
      d_man  = '0;
      d_snan = 1'b0;
      d_imz  = 1'b0;
      d_go   = 1'b0;
      if (cls_is_nan(hv_cls)) begin
         d_cls  = hv_cls;
         d_exp  = hv_exp;
         d_man  = hv_man;
         d_snan = 1'b1;
      end else if (hv_cls == CLS_INF) begin
         if (lt_cls == CLS_ZERO) begin
            d_cls = CLS_QNAN;
            d_sgn = 1'b0;
            d_exp = DNAN_EXP;
            d_man = DNAN_MAN;
            d_imz = 1'b1;
         end else begin
            d_cls = CLS_INF;
            d_exp = hv_exp;
            d_man = hv_man;
         end
      end else if (lt_cls == CLS_ZERO) begin
         d_cls = CLS_ZERO;
         d_exp = lt_exp;
         d_man = lt_man;
      end else begin
         d_go = 1'b1;
      end
   end
endmodule

// File: rtl/msr_stage.sv
module msr_stage
   import msr_pkg::*;
#(
   parameter int EXP_W      = 11,
   parameter int MANT_W     = 53,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CLS_W-1:0]  d_cls,
   input  logic              d_sgn,
   input  logic [EXP_W-1:0]  d_exp,
   input  logic [MANT_W-1:0] d_man,
   input  logic              d_snan,
   input  logic              d_imz,
   input  logic              d_go,
   output logic [CLS_W-1:0]  q_cls,
   output logic              q_sgn,
   output logic [EXP_W-1:0]  q_exp,
   output logic [MANT_W-1:0] q_man,
   output logic              q_snan,
   output logic              q_imz,
   output logic              q_go
);
   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q_cls  <= CLS_ZERO;
               q_sgn  <= 1'b0;
               q_exp  <= '0;
               q_man  <= '0;
               q_snan <= 1'b0;
               q_imz  <= 1'b0;
               q_go   <= 1'b0;
            end else begin
               q_cls  <= d_cls;
               q_sgn  <= d_sgn;
               q_exp  <= d_exp;
               q_man  <= d_man;
               q_snan <= d_snan;
               q_imz  <= d_imz;
               q_go   <= d_go;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q_cls  = d_cls;
         assign q_sgn  = d_sgn;
         assign q_exp  = d_exp;
         assign q_man  = d_man;
         assign q_snan = d_snan;
         assign q_imz  = d_imz;
         assign q_go   = d_go;
      end
   endgenerate
endmodule

// File: rtl/mul_special_resolve.sv
module mul_special_resolve
   import msr_pkg::*;
#(
   parameter int EXP_W      = 11,
   parameter int MANT_W     = 53,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        a_cls,
   input  logic              a_sgn,
   input  logic [EXP_W-1:0]  a_exp,
   input  logic [MANT_W-1:0] a_man,
   input  logic [2:0]        b_cls,
   input  logic              b_sgn,
   input  logic [EXP_W-1:0]  b_exp,
   input  logic [MANT_W-1:0] b_man,
   output logic [2:0]        res_cls,
   output logic              res_sgn,
   output logic [EXP_W-1:0]  res_exp,
   output logic [MANT_W-1:0] res_man,
   output logic              flag_snan,
   output logic              flag_imz,
   output logic              compute
);
   initial begin
      if (EXP_W < 2)  $error("EXP_W must be at least 2");
      if (MANT_W < 2) $error("MANT_W must be at least 2");
   end

   logic [CLS_W-1:0]  lt_cls, hv_cls, d_cls;
   logic              lt_sgn, hv_sgn, d_sgn, d_snan, d_imz, d_go;
   logic [EXP_W-1:0]  lt_exp, hv_exp, d_exp;
   logic [MANT_W-1:0] lt_man, hv_man, d_man;

   msr_order #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_order (
      .a_cls(a_cls), .a_sgn(a_sgn), .a_exp(a_exp), .a_man(a_man),
      .b_cls(b_cls), .b_sgn(b_sgn), .b_exp(b_exp), .b_man(b_man),
      .lt_cls(lt_cls), .lt_sgn(lt_sgn), .lt_exp(lt_exp), .lt_man(lt_man),
      .hv_cls(hv_cls), .hv_sgn(hv_sgn), .hv_exp(hv_exp), .hv_man(hv_man)
   );

   msr_decide #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_decide (
      .lt_cls(lt_cls), .lt_sgn(lt_sgn), .lt_exp(lt_exp), .lt_man(lt_man),
      .hv_cls(hv_cls), .hv_sgn(hv_sgn), .hv_exp(hv_exp), .hv_man(hv_man),
      .d_cls(d_cls), .d_sgn(d_sgn), .d_exp(d_exp), .d_man(d_man),
      .d_snan(d_snan), .d_imz(d_imz), .d_go(d_go)
   );

   msr_stage #(.EXP_W(EXP_W), .MANT_W(MANT_W), .REGISTERED(REGISTERED)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .d_cls(d_cls), .d_sgn(d_sgn), .d_exp(d_exp), .d_man(d_man),
      .d_snan(d_snan), .d_imz(d_imz), .d_go(d_go),
      .q_cls(res_cls), .q_sgn(res_sgn), .q_exp(res_exp), .q_man(res_man),
      .q_snan(flag_snan), .q_imz(flag_imz), .q_go(compute)
   );
endmodule

// File: rtl/msr_chk.sv
module msr_chk
   import msr_pkg::*;
#(
   parameter int EXP_W      = 11,
   parameter int MANT_W     = 53,
   parameter bit REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        a_cls,
   input logic              a_sgn,
   input logic [2:0]        b_cls,
   input logic              b_sgn,
   input logic [2:0]        res_cls,
   input logic              res_sgn,
   input logic [MANT_W-1:0] res_man,
   input logic              flag_snan,
   input logic              flag_imz,
   input logic              compute
);
   localparam logic [MANT_W-1:0] DNAN_MAN = {1'b1, {(MANT_W-1){1'b0}}};

   logic [2:0] pa_cls, pb_cls;
   logic       pa_sgn, pb_sgn, armed;

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk) begin
            armed  <= rst_n;
            pa_cls <= a_cls;
            pb_cls <= b_cls;
            pa_sgn <= a_sgn;
            pb_sgn <= b_sgn;
         end
      end else begin : g_comb
         assign armed  = 1'b1;
         assign pa_cls = a_cls;
         assign pb_cls = b_cls;
         assign pa_sgn = a_sgn;
         assign pb_sgn = b_sgn;
      end
   endgenerate

   // R6
   go_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed === 1'b1) && compute |-> pa_cls == CLS_NUM && pb_cls == CLS_NUM && !flag_snan && !flag_imz);
   // R7
   go_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed === 1'b1) && pa_cls == CLS_NUM && pb_cls == CLS_NUM |-> compute);
   // R2
   excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flag_snan, flag_imz, compute}));
   // R3
   imz_dnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed === 1'b1) && flag_imz |-> res_cls == CLS_QNAN && !res_sgn && res_man == DNAN_MAN);
   // R4
   sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed === 1'b1) && !flag_imz |-> res_sgn == (pa_sgn ^ pb_sgn));
   // R9
   snan_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed === 1'b1) && (cls_fold(pa_cls) == CLS_SNAN || cls_fold(pb_cls) == CLS_SNAN)
      |-> flag_snan && res_cls == CLS_SNAN);
endmodule

bind mul_special_resolve msr_chk #(.EXP_W(EXP_W), .MANT_W(MANT_W), .REGISTERED(REGISTERED)) u_chk (
   .clk(clk), .rst_n(rst_n), .a_cls(a_cls), .a_sgn(a_sgn), .b_cls(b_cls), .b_sgn(b_sgn),
   .res_cls(res_cls), .res_sgn(res_sgn), .res_man(res_man),
   .flag_snan(flag_snan), .flag_imz(flag_imz), .compute(compute)
);

// File: tb/mul_special_resolve_tb.sv
module mul_special_resolve_tb;
   localparam int CLK_PERIOD = 10;
   localparam int E = 6;
   localparam int M = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] a_cls = '0, b_cls = '0;
   logic a_sgn = 1'b0, b_sgn = 1'b0;
   logic [E-1:0] a_exp = '0, b_exp = '0;
   logic [M-1:0] a_man = '0, b_man = '0;
   logic [2:0] res_cls;
   logic res_sgn, flag_snan, flag_imz, compute;
   logic [E-1:0] res_exp;
   logic [M-1:0] res_man;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mul_special_resolve #(.EXP_W(E), .MANT_W(M), .REGISTERED(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .a_cls(a_cls), .a_sgn(a_sgn), .a_exp(a_exp), .a_man(a_man),
      .b_cls(b_cls), .b_sgn(b_sgn), .b_exp(b_exp), .b_man(b_man),
      .res_cls(res_cls), .res_sgn(res_sgn), .res_exp(res_exp), .res_man(res_man),
      .flag_snan(flag_snan), .flag_imz(flag_imz), .compute(compute)
   );

   localparam int VW = 3 + 1 + E + M + 3;
   function automatic logic [VW-1:0] pack_out();
      return {res_cls, res_sgn, res_exp, res_man, flag_snan, flag_imz, compute};
   endfunction

   logic [VW-1:0] e_vec;
   string e_tag;

   task automatic model();
      logic [2:0] wa, wb, c1, c2;
      logic s1, s2;
      logic [E-1:0] x1, x2;
      logic [M-1:0] m1, m2;
      wa = (a_cls > 3'd4) ? 3'd4 : a_cls;  // R9
      wb = (b_cls > 3'd4) ? 3'd4 : b_cls;
      if (wa > wb) begin  // R1
         c1 = wb; s1 = b_sgn; x1 = b_exp; m1 = b_man;
         c2 = wa; s2 = a_sgn; x2 = a_exp; m2 = a_man;
      end else begin
         c1 = wa; s1 = a_sgn; x1 = a_exp; m1 = a_man;
         c2 = wb; s2 = b_sgn; x2 = b_exp; m2 = b_man;
      end
      if (c2 >= 3'd3) begin
         e_vec = {c2, s1 ^ s2, x2, m2, 3'b100}; e_tag = "R2";
      end else if (c2 == 3'd2 && c1 == 3'd0) begin
         e_vec = {3'd3, 1'b0, {E{1'b1}}, 1'b1, {(M-1){1'b0}}, 3'b010}; e_tag = "R3";
      end else if (c2 == 3'd2) begin
         e_vec = {3'd2, s1 ^ s2, x2, m2, 3'b000}; e_tag = "R4";
      end else if (c1 == 3'd0) begin
         e_vec = {3'd0, s1 ^ s2, x1, m1, 3'b000}; e_tag = "R5";
      end else begin
         e_vec = {3'd1, s1 ^ s2, {E{1'b0}}, {M{1'b0}}, 3'b001}; e_tag = "R6";
      end
   endtask

   task automatic check(input string tag, input logic [VW-1:0] exp_v);
      checks++;
      if (pack_out() !== exp_v) begin
         errors++;
         $display("FAIL %s a_cls=%0d b_cls=%0d actual=%h expected=%h", tag, a_cls, b_cls, pack_out(), exp_v);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [VW-1:0] held;
      a_cls = 3'd2; b_cls = 3'd3; a_man = 10'h155; b_man = 10'h2aa;
      repeat (3) @(negedge clk);
      // R8: reset values while rst_n is low
      check("R8", '0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int ca = 0; ca < 8; ca++) begin
         for (int cb = 0; cb < 8; cb++) begin
            for (int sg = 0; sg < 4; sg++) begin
               a_cls = ca[2:0]; b_cls = cb[2:0];
               a_sgn = sg[0]; b_sgn = sg[1];
               a_exp = E'(ca * 5 + 3); b_exp = E'(cb * 7 + 33);
               a_man = M'(ca * 97 + 11); b_man = M'(cb * 61 + 512);
               model();
               @(negedge clk);
               // R1 tie/ordering, R2-R7, R9 covered by the expected vector
               check(e_tag, e_vec);
               if (ca == 4 && cb == 3) check("R1", e_vec);
               if (ca > 4 || cb > 4) check("R9", e_vec);
               if (e_tag != "R6") check("R7", {e_vec[VW-1:1], 1'b0});
            end
         end
      end
      // R8: output holds old value until the next edge
      a_cls = 3'd1; b_cls = 3'd1; a_sgn = 1'b0; b_sgn = 1'b1;
      @(negedge clk);
      held = pack_out();
      a_cls = 3'd0; b_cls = 3'd2;
      #1;
      check("R8", held);
      @(negedge clk);
      check("R8", {3'd3, 1'b0, {E{1'b1}}, 1'b1, {(M-1){1'b0}}, 3'b010});
      // R8: synchronous reset clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      check("R8", '0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule